// File: doc/BRIEF.md
# Receive Frame Length Checker

This block sits on the receive byte path of an Ethernet-style MAC. It sees one strobe when a frame begins (right after the start-frame delimiter), one strobe for each data byte, and one strobe at the end of the frame. It counts the in-frame bytes and compares the final count against two programmable limits, a longest and a shortest frame length. When the frame closes it presents, for one cycle, a status word for the frame's last buffer. The word holds the byte count, a too-long flag and a too-short flag, together with a keep or drop decision.

An oversize frame is never cut short. A live `too_long` output rises as soon as the count passes the maximum and stays high until the next frame begins. The frame is still counted to its real end and is accepted, with the flag set. An undersize frame is dropped unless `keep_short` is set. When `keep_short` is set, the short frame is accepted and flagged. The byte counter saturates, so a frame longer than the counter's range reports the largest count and never a small wrapped value.

Control is a three-state machine. `IDLE` waits for a frame. `RECV` counts bytes. `REPORT` presents the status for exactly one cycle. The transitions are:
- START: `IDLE` to `RECV` on `sof`.
- RESTART: `RECV` to `RECV` on `sof`. The count is cleared and the old frame is abandoned without a report.
- CLOSE: `RECV` to `REPORT` on `eof`.
- CHAIN: `REPORT` to `RECV` on `sof`.
- RETIRE: `REPORT` to `IDLE` otherwise.

Top module: `rx_len_checker`

## Requirements
- R1: After reset the longest-frame limit is 1518, the shortest-frame limit is 64, and `stat_vld`, `accept`, `discard` and `too_long` are 0.
- R2: A frame's length is the number of cycles with `byte_vld` high while in a frame. The cycle carrying `sof` never counts. A byte on the same cycle as `eof` does count.
- R3: The status (`stat_vld`, `stat_len`, `stat_long`, `stat_short`, `accept`, `discard`) appears on the cycle after the `eof` edge and lasts exactly one cycle.
- R4: A write strobe `wr_max` or `wr_min` loads `lim_wdata` into the longest or shortest limit at the clock edge.
- R5: A frame whose length is greater than the longest limit reports `stat_long`=1 and is not dropped for that reason.
- R6: `too_long` goes high on the cycle after the byte that takes the count past the longest limit, and stays high until the next `sof`.
- R7: A frame whose length equals the longest limit or the shortest limit sets neither flag and is accepted.
- R8: With `keep_short`=0, a frame shorter than the shortest limit reports `stat_short`=1, `discard`=1 and `accept`=0.
- R9: With `keep_short`=1, a frame shorter than the shortest limit reports `stat_short`=1, `accept`=1 and `discard`=0.
- R10: The byte count saturates at 2^LEN_W-1, and that value is reported for any longer frame.
- R11: A `sof` inside a frame restarts the count with no status for the abandoned frame. An `eof` outside a frame produces no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Frame begins (after the delimiter) |
| byte_vld | input | 1 | One in-frame byte this cycle |
| eof | input | 1 | Frame ends this cycle |
| keep_short | input | 1 | 1 = keep undersize frames with a flag |
| wr_max | input | 1 | Load the longest-frame limit |
| wr_min | input | 1 | Load the shortest-frame limit |
| lim_wdata | input | LEN_W | Limit write value |
| too_long | output | 1 | Live oversize indication |
| stat_vld | output | 1 | Status word valid |
| stat_len | output | LEN_W | Frame length in bytes |
| stat_long | output | 1 | Frame longer than the limit |
| stat_short | output | 1 | Frame shorter than the limit |
| accept | output | 1 | Frame is kept |
| discard | output | 1 | Frame is dropped |

## Verification
The assertions that compare the reported flags with the limits assume the limits stay fixed from `sof` until the report has retired. The bench therefore writes the limits only while the block is idle. It also assumes that `byte_vld` and `eof` are driven only inside a frame, apart from the deliberate stray `eof` used for R11. The bench sweeps every frame length from 0 to past the longest limit, with small limits and in both `keep_short` modes. It varies whether `eof` rides on the last byte, and computes each expected status from the length alone.

// File: rtl/rx_len_pkg.sv
package rx_len_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RECV   = 2'd1,
        ST_REPORT = 2'd2
    } rx_state_e;

endpackage

// File: rtl/rx_len_limits.sv
module rx_len_limits #(
    parameter int LEN_W   = 16,
    parameter int MAX_RST = 1518,
    parameter int MIN_RST = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_max,
    input  logic             wr_min,
    input  logic [LEN_W-1:0] wdata,
    output logic [LEN_W-1:0] lim_max,
    output logic [LEN_W-1:0] lim_min
);
    localparam logic [LEN_W-1:0] MAX_INIT = LEN_W'(MAX_RST);
    localparam logic [LEN_W-1:0] MIN_INIT = LEN_W'(MIN_RST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_max <= MAX_INIT;
            lim_min <= MIN_INIT;
        end else begin
            if (wr_max) lim_max <= wdata;
            if (wr_min) lim_min <= wdata;
        end
    end
endmodule

// File: rtl/rx_len_counter.sv
module rx_len_counter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [LEN_W-1:0] cnt_nxt
);
    localparam logic [LEN_W-1:0] CNT_TOP = {LEN_W{1'b1}};

    logic [LEN_W-1:0] cnt_q;

    // saturating step: a full counter holds instead of wrapping
    always_comb begin
        if (clr)
            cnt_nxt = '0;
        else if (inc && (cnt_q != CNT_TOP))
            cnt_nxt = cnt_q + 1'b1;
        else
            cnt_nxt = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/rx_len_fsm.sv
module rx_len_fsm
    import rx_len_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic eof,
    input  logic byte_vld,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic close,
    output logic in_report
);
    rx_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        close     = 1'b0;
        in_report = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sof) begin                // START
                    cnt_clr = 1'b1;
                    state_d = ST_RECV;
                end
            end
            ST_RECV: begin
                if (sof) begin                // RESTART
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = byte_vld;
                    if (eof) begin            // CLOSE
                        close   = 1'b1;
                        state_d = ST_REPORT;
                    end
                end
            end
            ST_REPORT: begin
                in_report = 1'b1;
                if (sof) begin                // CHAIN
                    cnt_clr = 1'b1;
                    state_d = ST_RECV;
                end else begin                // RETIRE
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/rx_len_checker.sv
module rx_len_checker #(
    parameter int LEN_W   = 16,
    parameter int MAX_RST = 1518,
    parameter int MIN_RST = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             byte_vld,
    input  logic             eof,
    input  logic             keep_short,
    input  logic             wr_max,
    input  logic             wr_min,
    input  logic [LEN_W-1:0] lim_wdata,
    output logic             too_long,
    output logic             stat_vld,
    output logic [LEN_W-1:0] stat_len,
    output logic             stat_long,
    output logic             stat_short,
    output logic             accept,
    output logic             discard
);
    logic [LEN_W-1:0] lim_max, lim_min, cnt_nxt;
    logic             cnt_clr, cnt_inc, close, in_report;
    logic             long_q, short_q, drop_q;
    logic [LEN_W-1:0] len_q;

    rx_len_limits #(.LEN_W(LEN_W), .MAX_RST(MAX_RST), .MIN_RST(MIN_RST)) limits_i (
        .clk(clk), .rst_n(rst_n), .wr_max(wr_max), .wr_min(wr_min),
        .wdata(lim_wdata), .lim_max(lim_max), .lim_min(lim_min)
    );

    rx_len_counter #(.LEN_W(LEN_W)) counter_i (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt_nxt(cnt_nxt)
    );

    rx_len_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof), .byte_vld(byte_vld),
        .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .close(close), .in_report(in_report)
    );

    // live oversize flag: set on the byte that passes the limit, held to next sof
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            long_q <= 1'b0;
        else if (cnt_clr)
            long_q <= 1'b0;
        else if (cnt_inc && (cnt_nxt > lim_max))
            long_q <= 1'b1;
    end

    // last-buffer status, captured at the closing edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            short_q <= 1'b0;
            drop_q  <= 1'b0;
        end else if (close) begin
            len_q   <= cnt_nxt;
            short_q <= (cnt_nxt < lim_min);
            drop_q  <= (cnt_nxt < lim_min) && !keep_short;
        end
    end

    always_comb begin
        too_long   = long_q;
        stat_vld   = in_report;
        stat_len   = len_q;
        stat_long  = in_report && long_q;
        stat_short = in_report && short_q;
        accept     = in_report && !drop_q;
        discard    = in_report && drop_q;
    end
endmodule

// File: rtl/rx_len_checker_chk.sv
module rx_len_checker_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sof,
    input logic             eof,
    input logic             keep_short,
    input logic             too_long,
    input logic             stat_vld,
    input logic [LEN_W-1:0] stat_len,
    input logic             stat_long,
    input logic             stat_short,
    input logic             accept,
    input logic             discard,
    input logic [LEN_W-1:0] lim_max,
    input logic [LEN_W-1:0] lim_min
);
    AST_REPORT_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> $past(eof));                                          // R3
    AST_REPORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |=> !stat_vld);                                           // R3
    AST_LONG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (too_long && !sof) |=> too_long);                                  // R6
    AST_LONG_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> (stat_long == too_long));                             // R5
    AST_LONG_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> (stat_long == (stat_len > lim_max)));                 // R7
    AST_SHORT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> (stat_short == (stat_len < lim_min)));                // R9
    AST_DROP_ONLY_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        discard |-> (stat_short && !keep_short));                          // R8
    AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> (accept != discard));                                 // R8
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_vld |-> !(accept || discard || stat_long || stat_short));    // R3
endmodule

bind rx_len_checker rx_len_checker_chk #(.LEN_W(LEN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof), .keep_short(keep_short),
    .too_long(too_long), .stat_vld(stat_vld), .stat_len(stat_len),
    .stat_long(stat_long), .stat_short(stat_short), .accept(accept),
    .discard(discard), .lim_max(lim_max), .lim_min(lim_min)
);

// File: tb/rx_len_checker_tb_top.sv
module rx_len_checker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 16;
    localparam int CNT_TOP    = (1 << LEN_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sof = 1'b0, byte_vld = 1'b0, eof = 1'b0, keep_short = 1'b0;
    logic             wr_max = 1'b0, wr_min = 1'b0;
    logic [LEN_W-1:0] lim_wdata = '0;
    logic             too_long, stat_vld, stat_long, stat_short, accept, discard;
    logic [LEN_W-1:0] stat_len;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int cur_max = 1518;
    int cur_min = 64;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_len_checker #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld), .eof(eof),
        .keep_short(keep_short), .wr_max(wr_max), .wr_min(wr_min),
        .lim_wdata(lim_wdata), .too_long(too_long), .stat_vld(stat_vld),
        .stat_len(stat_len), .stat_long(stat_long), .stat_short(stat_short),
        .accept(accept), .discard(discard)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_limits(input int mx, input int mn);
        @(negedge clk);
        wr_max = 1'b1; wr_min = 1'b0; lim_wdata = LEN_W'(mx);
        @(negedge clk);
        wr_max = 1'b0; wr_min = 1'b1; lim_wdata = LEN_W'(mn);
        @(negedge clk);
        wr_min = 1'b0;
        cur_max = mx; cur_min = mn;
    endtask

    // n bytes; eof on last byte when joined; live flag checked when probe set
    task automatic frame(input int n, input bit joined, input bit probe, input string tag);
        int exp_len;
        bit e_long, e_short;
        @(negedge clk);
        sof = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sof = 1'b0;
            if (probe && (i == cur_max || i == cur_max + 1))
                check({tag, " R6 too_long live"}, too_long, i > cur_max);
            byte_vld = 1'b1;
            eof = joined && (i == n - 1);
        end
        @(negedge clk);
        sof = 1'b0; byte_vld = 1'b0;
        if (!joined || n == 0) begin
            eof = 1'b1;
            @(negedge clk);
        end
        eof = 1'b0;
        exp_len = (n > CNT_TOP) ? CNT_TOP : n;
        e_long  = exp_len > cur_max;
        e_short = exp_len < cur_min;
        check({tag, " R3 stat_vld"}, stat_vld, 1);
        check({tag, " R2 R10 stat_len"}, stat_len, exp_len);
        check({tag, " R5 R7 stat_long"}, stat_long, e_long);
        check({tag, " R7 R8 R9 stat_short"}, stat_short, e_short);
        check({tag, " R8 R9 accept"}, accept, !e_short || keep_short);
        check({tag, " R8 R9 discard"}, discard, e_short && !keep_short);
        @(negedge clk);
        check({tag, " R3 single cycle"}, stat_vld, 0);
        check({tag, " R6 flag held"}, too_long, e_long);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 stat_vld", stat_vld, 0);
        check("R1 accept", accept, 0);
        check("R1 discard", discard, 0);
        check("R1 too_long", too_long, 0);
        rst_n = 1'b1;
        // reset limits seen through behaviour: 1518 / 64
        frame(1518, 1, 0, "rst max edge R1");
        frame(1519, 0, 1, "rst max+1 R1");
        frame(64, 1, 0, "rst min edge R1");
        frame(63, 0, 0, "rst min-1 R1");
        // R4: new limits, then a sweep in both modes and both eof placements
        set_limits(16, 6);
        for (int m = 0; m < 2; m++) begin
            keep_short = m[0];
            for (int n = 0; n <= 22; n++)
                frame(n, n[0], 1, $sformatf("R4 sweep mode=%0d n=%0d", m, n));
        end
        keep_short = 1'b0;
        // R11: restart inside a frame
        @(negedge clk);
        sof = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); sof = 1'b0; byte_vld = 1'b1;
        end
        @(negedge clk);
        byte_vld = 1'b0; sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        check("R11 no status on restart", stat_vld, 0);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); byte_vld = 1'b1; eof = (i == 6);
        end
        @(negedge clk);
        byte_vld = 1'b0; eof = 1'b0;
        check("R11 restart stat_vld", stat_vld, 1);
        check("R11 restart len", stat_len, 7);
        // R11: stray eof while idle
        repeat (2) @(negedge clk);
        eof = 1'b1;
        @(negedge clk);
        eof = 1'b0;
        @(negedge clk);
        check("R11 stray eof", stat_vld, 0);
        // R10: saturation
        set_limits(100, 6);
        frame(CNT_TOP + 5, 0, 0, "R10 saturate");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule